// File: doc/BRIEF.md
# Serial Command Frame Receiver

This block is the write-only front end of a serial slave port in a multi-channel converter controller. It samples an active-low frame select, a serial clock and a serial data line with the system clock. It shifts in a 32-bit word, most significant bit first, taking one bit on each falling edge of the serial clock. When the last bit arrives it presents the command, address and data fields of the word with a one-cycle valid strobe. A separate block stores registers and executes commands.

A frame that ends early is dropped. This happens when the select line rises before the final falling edge, or when the system-side clear input is raised during the frame. The dropped frame produces a one-cycle abort pulse and leaves the field outputs as they were. Once a frame has completed, further serial clock edges are ignored until the select line goes high again. The next frame starts only when the select line falls after that. The system clock must run at least four times faster than the serial clock.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, frame_valid_o and frame_abort_o are 0 and cmd_o, addr_o and data_o are all 0.
- R2: A frame holds 32 bits, most significant first. Word bits 27:24 appear on cmd_o, bits 23:20 on addr_o and bits 19:4 on data_o. Bits 31:28 and 3:0 are ignored.
- R3: frame_valid_o is high for exactly one cycle per completed frame. cmd_o, addr_o and data_o change only together with that strobe and hold their values until the next completed frame.
- R4: If sync_ni rises before the 32nd falling edge of sclk_i, no strobe is issued and frame_abort_o pulses once. The fields keep their previous values. The partial bits are discarded, so the next full frame decodes correctly.
- R5: The strobe is issued on the 32nd falling edge whether or not sync_ni stays low. With sync_ni held low after the strobe, further sclk_i falling edges produce no strobe and no field change.
- R6: After a completed frame, a new frame starts only when sync_ni goes high and then falls again.
- R7: clear_i high for a cycle during a frame aborts it: frame_abort_o pulses and no strobe is issued. The remaining sclk_i edges are ignored until sync_ni goes high and falls again.
- R8: frame_valid_o rises in the third system clock cycle after the 32nd falling edge of sclk_i reaches the pin. The same three-cycle delay applies from a sync_ni rise to frame_abort_o. The three cycles are two synchronizer stages plus one register.
- R9: sclk_i falling edges while sync_ni is high cause neither a strobe nor an abort, and do not disturb the next frame.
- R10: clear_i raised outside a frame (sync_ni high, or after a completed frame) causes no abort pulse and does not block the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_ni | input | 1 | Active-low frame select, asynchronous |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| din_i | input | 1 | Serial data, most significant bit first |
| clear_i | input | 1 | System-domain clear; aborts a frame in progress |
| frame_valid_o | output | 1 | One-cycle strobe for a completed frame |
| frame_abort_o | output | 1 | One-cycle pulse for a dropped frame |
| cmd_o | output | 4 | Command field of the last completed frame |
| addr_o | output | 4 | Address field of the last completed frame |
| data_o | output | 16 | Data field of the last completed frame |

## Verification
Each pin event takes three system clock cycles to reach the outputs: two synchronizer stages and one output register. The bench drives pins on the falling system clock edge and checks the strobe on the second, third and fourth falling edges after the final serial clock fall. It expects the strobe to be low, then high, then low again. A clear_i pulse takes effect through the register alone, so its abort is due one cycle later. For aborts and for stimulus that must cause nothing, a monitor counts strobe and abort pulses a few nanoseconds after each rising edge. Each task then compares those counts and the held fields after enough cycles have passed for any late pulse to appear.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;
  localparam int FRAME_BITS = 32;
  localparam int CMD_W      = 4;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 16;
  localparam int CMD_LSB    = 24;
  localparam int ADDR_LSB   = 20;
  localparam int DATA_LSB   = 4;

  typedef enum logic [1:0] {
    ST_WAIT_HIGH,
    ST_READY,
    ST_SHIFT,
    ST_DONE
  } rx_state_e;
endpackage

// File: rtl/frame_rx_sync.sv
module frame_rx_sync #(
  parameter int                 WIDTH     = 3,
  parameter int                 STAGES    = 2,
  parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RESET_VAL;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RESET_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/frame_rx_edge.sv
module frame_rx_edge #(
  parameter int               WIDTH     = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RESET_VAL;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/frame_rx_core.sv
module frame_rx_core
  import frame_rx_pkg::*;
#(
  parameter int BITS = FRAME_BITS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sync_lvl_i,
  input  logic            sync_rise_i,
  input  logic            sync_fall_i,
  input  logic            sclk_fall_i,
  input  logic            din_i,
  input  logic            clear_i,
  output logic            valid_o,
  output logic            abort_o,
  output logic [BITS-1:0] word_o
);
  localparam int                CNT_W    = $clog2(BITS);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BITS - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BITS-1:0]  shreg_q;
  logic [BITS-1:0]  word_q;
  logic             valid_q, abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_READY;
      cnt_q   <= '0;
      shreg_q <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      abort_q <= 1'b0;
      unique case (state_q)
        ST_WAIT_HIGH: if (sync_lvl_i) state_q <= ST_READY;
        ST_READY: begin
          if (sync_fall_i) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            state_q <= clear_i ? ST_WAIT_HIGH : ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (sync_rise_i || clear_i) begin
            // early end of frame: drop partial bits
            abort_q <= 1'b1;
            cnt_q   <= '0;
            shreg_q <= '0;
            state_q <= sync_rise_i ? ST_READY : ST_WAIT_HIGH;
          end else if (sclk_fall_i) begin
            shreg_q <= {shreg_q[BITS-2:0], din_i};
            if (cnt_q == LAST_BIT) begin
              word_q  <= {shreg_q[BITS-2:0], din_i};
              valid_q <= 1'b1;
              cnt_q   <= '0;
              state_q <= ST_DONE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_DONE: if (sync_rise_i) state_q <= ST_READY;
        default: state_q <= ST_WAIT_HIGH;
      endcase
    end
  end

  assign valid_o = valid_q;
  assign abort_o = abort_q;
  assign word_o  = word_q;

  p_valid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  p_word_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_q) |-> valid_q);
  p_valid_abort_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_q && abort_q));
  p_valid_from_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (state_q == ST_DONE) && ($past(state_q) == ST_SHIFT));
  p_done_ignores_sclk_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) && !sync_rise_i |=> (state_q == ST_DONE) && !valid_q);
  p_sync_abort_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT) && sync_rise_i |=> abort_q && (state_q == ST_READY));
  p_clear_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT) && clear_i |=> abort_q);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READY) |=> !valid_q && !abort_q);
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import frame_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BITS        = FRAME_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic              clear_i,
  output logic              frame_valid_o,
  output logic              frame_abort_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic [2:0]      pins_s;
  logic [1:0]      rise, fall;
  logic [BITS-1:0] word;

  // pins_s: {sync, sclk, din}; select and clock idle high
  frame_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b110)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sync_ni, sclk_i, din_i}),
    .q_o    (pins_s)
  );

  frame_rx_edge #(.WIDTH(2), .RESET_VAL(2'b11)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (pins_s[2:1]),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  frame_rx_core #(.BITS(BITS)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_lvl_i  (pins_s[2]),
    .sync_rise_i (rise[1]),
    .sync_fall_i (fall[1]),
    .sclk_fall_i (fall[0]),
    .din_i       (pins_s[0]),
    .clear_i     (clear_i),
    .valid_o     (frame_valid_o),
    .abort_o     (frame_abort_o),
    .word_o      (word)
  );

  assign cmd_o  = word[CMD_LSB  +: CMD_W];
  assign addr_o = word[ADDR_LSB +: ADDR_W];
  assign data_o = word[DATA_LSB +: DATA_W];
endmodule

// File: tb/serial_frame_rx_bench.sv
module serial_frame_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_n = 1'b1, sclk = 1'b1, din = 1'b0, clear = 1'b0;
  logic        valid, abort_p;
  logic [3:0]  cmd, addr;
  logic [15:0] data;
  int checks = 0, fails = 0, vcnt = 0, acnt = 0;
  bit done = 1'b0;
  logic [3:0]  e_cmd = '0, e_addr = '0;
  logic [15:0] e_data = '0;

  always #10 clk = ~clk;

  serial_frame_rx u_serial_frame_rx (
    .clk_i(clk), .rst_ni(rst_n), .sync_ni(sync_n), .sclk_i(sclk), .din_i(din),
    .clear_i(clear), .frame_valid_o(valid), .frame_abort_o(abort_p),
    .cmd_o(cmd), .addr_o(addr), .data_o(data)
  );

  always @(posedge clk) begin
    #2;
    if (valid)   vcnt++;
    if (abort_p) acnt++;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
    return {4'hF, c, a, d, 4'hF};
  endfunction

  task automatic bits(input logic [31:0] w, input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      din = w[31-i]; sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    sclk = 1'b1;
  endtask

  task automatic start_frame();
    sync_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic end_frame();
    sync_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_fields(input string tag);
    check(cmd == e_cmd, {tag, " cmd"}, cmd, e_cmd);
    check(addr == e_addr, {tag, " addr"}, addr, e_addr);
    check(data == e_data, {tag, " data"}, data, e_data);
  endtask

  // full frame, last bit timed: strobe due on the 3rd falling clk edge
  task automatic full_frame(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d, input bit raise);
    logic [31:0] w = mk(c, a, d);
    int v0 = vcnt;
    start_frame();
    bits(w, 0, 31);
    din = w[0];
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    check(valid == 1'b0, "R8 strobe early", valid, 0);
    @(negedge clk);
    check(valid == 1'b1, "R8 strobe at third cycle", valid, 1);
    @(negedge clk);
    check(valid == 1'b0, "R3 strobe one cycle", valid, 0);
    sclk = 1'b1;
    e_cmd = c; e_addr = a; e_data = d;
    check_fields("R2");
    check(vcnt == v0 + 1, "R3 one strobe per frame", vcnt, v0 + 1);
    if (raise) end_frame();
  endtask

  task automatic t_reset();
    check(valid == 0 && abort_p == 0, "R1 reset strobes", {valid, abort_p}, 0);
    check(cmd == 0 && addr == 0 && data == 0, "R1 reset fields", {cmd, addr, data}, 0);
  endtask

  task automatic t_basic();
    full_frame(4'h3, 4'h1, 16'hA5C3, 1'b1);
    full_frame(4'hC, 4'hE, 16'h0001, 1'b1);
    full_frame(4'h0, 4'h0, 16'h8000, 1'b1);
  endtask

  task automatic t_hold_low();
    int v0, a0;
    full_frame(4'h6, 4'h2, 16'h1234, 1'b0);
    v0 = vcnt; a0 = acnt;
    bits(32'h0FFF_FFF0, 0, 32);
    repeat (4) @(negedge clk);
    check(vcnt == v0, "R5 edges after strobe ignored", vcnt, v0);
    check_fields("R5 fields held");
    clear = 1'b1; @(negedge clk); clear = 1'b0;
    repeat (4) @(negedge clk);
    check(acnt == a0, "R10 clear after strobe no abort", acnt, a0);
    end_frame();
    full_frame(4'h9, 4'h7, 16'hBEEF, 1'b1);
    check(vcnt == v0 + 1, "R6 new frame after select high", vcnt, v0 + 1);
  endtask

  task automatic t_sync_abort();
    int v0 = vcnt, a0 = acnt;
    start_frame();
    bits(32'h0000_0000, 0, 12);
    sync_n = 1'b1;
    repeat (2) @(negedge clk);
    check(abort_p == 1'b0, "R8 abort early", abort_p, 0);
    @(negedge clk);
    check(abort_p == 1'b1, "R8 abort at third cycle", abort_p, 1);
    repeat (4) @(negedge clk);
    check(acnt == a0 + 1, "R4 one abort pulse", acnt, a0 + 1);
    check(vcnt == v0, "R4 no strobe", vcnt, v0);
    check_fields("R4 fields kept");
    full_frame(4'hF, 4'hF, 16'hFFFF, 1'b1);
  endtask

  task automatic t_clear_abort();
    int v0 = vcnt, a0 = acnt;
    logic [31:0] w = mk(4'h1, 4'h2, 16'h3333);
    start_frame();
    bits(w, 0, 10);
    clear = 1'b1; @(negedge clk); clear = 1'b0;
    @(negedge clk);
    check(acnt == a0 + 1, "R7 clear aborts", acnt, a0 + 1);
    bits(w, 10, 22);
    repeat (4) @(negedge clk);
    check(vcnt == v0, "R7 no strobe after clear", vcnt, v0);
    check_fields("R7 fields kept");
    end_frame();
    check(acnt == a0 + 1, "R7 no second abort", acnt, a0 + 1);
    full_frame(4'h5, 4'hA, 16'h5A5A, 1'b1);
  endtask

  task automatic t_stray();
    int v0 = vcnt, a0 = acnt;
    bits(32'hFFFF_FFFF, 0, 32);
    clear = 1'b1; @(negedge clk); clear = 1'b0;
    repeat (4) @(negedge clk);
    check(vcnt == v0, "R9 stray clocks no strobe", vcnt, v0);
    check(acnt == a0, "R9 R10 idle no abort", acnt, a0);
    full_frame(4'h2, 4'h4, 16'h0F0F, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_hold_low();
    t_sync_abort();
    t_clear_abort();
    t_stray();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule